// File: doc/BRIEF.md
# Chainable Fragment SPI Master

This block is an SPI master, mode 0 only, that moves one fragment of a transfer for each command it accepts. A command carries a bit count from 0 to 32, an end-of-packet flag, a write-only flag and a left-aligned 32-bit write word. The active-low chip select stays asserted after a fragment that has end-of-packet clear, so software or a sequencer can build frames longer than 32 bits, or frames whose length is only known at run time. Each fragment is sent as a separate command. A fragment with end-of-packet set returns chip select to idle once it has shifted its bits.

When a fragment that reads has finished, the bits it received are offered on a valid/ready output stream without any further request. As an example, a register read with an 8-bit opcode uses two commands: first (8, eop=0, write-only=1), then (32, eop=1, write-only=0). Chip select stays low across both, and only the second one returns a data word. There is one transfer register and no second buffer. The next command is accepted only when the bus is parked with chip select held, or when it is idle.

Top module: `frag_spi_master`

## Requirements
- R1: MOSI sends the write word MSB first. Bit i of a fragment, counting from 0, is cmd_wdata[31-i]. MOSI does not change while SCLK is high.
- R2: SCLK is low whenever chip select is released. Each high phase lasts DIV/2 clock cycles. A fragment of length N produces exactly N rising edges, and lengths above 32 are treated as 32.
- R3: MISO is sampled on the rising edges of SCLK. The returned word is right-aligned: bit 0 is the last bit received, bits at position N and above are zero, and the count of valid bits is the fragment length N.
- R4: A fragment with length above zero and write-only clear produces exactly one rd_valid item. Write-only fragments and zero-length fragments produce none. rd_valid and rd_data hold steady until rd_ready is high.
- R5: After a fragment with end-of-packet clear, cs_n stays low and SCLK stays low until the next command arrives.
- R6: After a fragment with end-of-packet set, cs_n goes high no earlier than DIV/2 cycles after the last falling edge of SCLK.
- R7: A zero-length command with end-of-packet set releases a held chip select and causes no SCLK edge. When chip select is already released, this command has no effect and cs_n stays high. A zero-length command with end-of-packet clear asserts chip select and holds it.
- R8: cs_n and SCLK are both low for at least DIV/2 cycles before any rising edge of SCLK.
- R9: cmd_ready is low while a fragment is shifting, and low while a read word waits for rd_ready.
- R10: busy is high whenever cs_n is low or a fragment is in progress. busy is low after a frame has been released.
- R11: After reset, cs_n is high, SCLK is low, busy is low, rd_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_len | input | LEN_W | Bit count of the fragment, 0 to DW; larger values are clamped |
| cmd_eop | input | 1 | Release chip select after this fragment |
| cmd_wo | input | 1 | Write-only: return no read word |
| cmd_wdata | input | DW | Write bits, left-aligned |
| rd_valid | output | 1 | A read word is offered |
| rd_ready | input | 1 | Downstream accepts the read word |
| rd_data | output | DW | Received bits, right-aligned |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | A frame is open or a fragment is running |

## Verification
The assertions check, on every cycle, the properties that concern the bus lines and handshakes:

- SCLK is quiet while chip select is released.
- MOSI holds still while SCLK is high.
- Chip select has its setup and hold margins around SCLK edges.
- cmd_ready stays low during shifting and while a read word is pending.
- A pending read word stays stable.

Only the bench scenarios can show the following, because each depends on the whole frame:

- The bit order on MOSI.
- The right-aligned content of read words drawn from a bit stream that continues across chained fragments.
- The number of edges per fragment.
- That chip select is held or released according to each flag.
- That zero-length commands have no effect, or only release the select.

// File: rtl/frag_spi_pkg.sv
package frag_spi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,   // chip select released
        PH_PARK,   // chip select held, waiting for the next command
        PH_LOW,    // SCLK low half period, MISO sampled at its end
        PH_HIGH,   // SCLK high half period, MOSI advances at its end
        PH_TAIL    // SCLK low hold time before chip select release
    } phase_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF == 1) begin : g_single
            assign tick = en;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!en) begin
                    cnt_d = '0;
                end else if (cnt_q == CW'(HALF - 1)) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = en && (cnt_q == CW'(HALF - 1));
        end
    endgenerate
endmodule

// File: rtl/spi_frag_shifter.sv
module spi_frag_shifter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          sample,
    input  logic          miso,
    input  logic          advance,
    output logic          mosi,
    output logic [DW-1:0] rx
);
    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } shreg_t;

    shreg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.tx = wdata;
            s_d.rx = '0;
        end else begin
            if (sample)  s_d.rx = {s_q.rx[DW-2:0], miso};
            if (advance) s_d.tx = {s_q.tx[DW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mosi = s_q.tx[DW-1];
    assign rx   = s_q.rx;
endmodule

// File: rtl/frag_spi_master.sv
module frag_spi_master
    import frag_spi_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DIV   = 4,
    parameter int LEN_W = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_eop,
    input  logic             cmd_wo,
    input  logic [DW-1:0]    cmd_wdata,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [DW-1:0]    rd_data,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    output logic             busy
);
    localparam int HALF = (DIV < 2) ? 1 : DIV / 2;

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] left;
        logic             eop;
        logic             wo;
        logic             rdv;
        logic [DW-1:0]    rdd;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          tick;
    logic          timer_en;
    logic          load, sample, advance;
    logic          accept;
    logic [DW-1:0] rx_word;
    logic [LEN_W-1:0] len_c;

    assign timer_en = (c_q.ph == PH_LOW) || (c_q.ph == PH_HIGH) || (c_q.ph == PH_TAIL);
    assign cmd_ready = ((c_q.ph == PH_IDLE) || (c_q.ph == PH_PARK)) && !c_q.rdv;
    assign accept    = cmd_valid && cmd_ready;
    assign len_c     = (cmd_len > LEN_W'(DW)) ? LEN_W'(DW) : cmd_len;

    always_comb begin
        c_d     = c_q;
        load    = 1'b0;
        sample  = 1'b0;
        advance = 1'b0;
        if (c_q.rdv && rd_ready) c_d.rdv = 1'b0;
        unique case (c_q.ph)
            PH_IDLE, PH_PARK: begin
                if (accept) begin
                    load     = 1'b1;
                    c_d.left = len_c;
                    c_d.eop  = cmd_eop;
                    c_d.wo   = cmd_wo;
                    if (len_c != '0)          c_d.ph = PH_LOW;
                    else if (!cmd_eop)        c_d.ph = PH_PARK;
                    else if (c_q.ph == PH_PARK) c_d.ph = PH_TAIL;
                    else                      c_d.ph = PH_IDLE;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    sample = 1'b1;
                    c_d.ph = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    advance  = 1'b1;
                    c_d.left = c_q.left - 1'b1;
                    if (c_q.left == LEN_W'(1)) begin
                        if (!c_q.wo) begin
                            c_d.rdv = 1'b1;
                            c_d.rdd = rx_word;
                        end
                        c_d.ph = c_q.eop ? PH_TAIL : PH_PARK;
                    end else begin
                        c_d.ph = PH_LOW;
                    end
                end
            end
            PH_TAIL: begin
                if (tick) c_d.ph = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.ph <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    spi_half_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (timer_en),
        .tick  (tick)
    );

    spi_frag_shifter #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wdata   (cmd_wdata),
        .sample  (sample),
        .miso    (miso),
        .advance (advance),
        .mosi    (mosi),
        .rx      (rx_word)
    );

    assign sclk     = (c_q.ph == PH_HIGH);
    assign cs_n     = (c_q.ph == PH_IDLE);
    assign busy     = (c_q.ph != PH_IDLE);
    assign rd_valid = c_q.rdv;
    assign rd_data  = c_q.rdd;
endmodule

// File: rtl/frag_spi_checker.sv
module frag_spi_checker #(
    parameter int DW       = 32,
    parameter int HALF_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sclk,
    input logic          mosi,
    input logic          cmd_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [DW-1:0] rd_data
);
    localparam int SW = $clog2(HALF_CYC + 1) + 1;

    // cycles spent with chip select low and SCLK low, saturating at HALF_CYC
    logic [SW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         quiet_q <= '0;
        else if (cs_n || sclk)              quiet_q <= '0;
        else if (quiet_q != SW'(HALF_CYC))  quiet_q <= quiet_q + 1'b1;
    end

    p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_ready_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cmd_ready);

    p_ready_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cmd_ready);

    p_cs_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (quiet_q >= SW'(HALF_CYC)));

    p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (quiet_q >= SW'(HALF_CYC)));
endmodule

bind frag_spi_master frag_spi_checker #(.DW(DW), .HALF_CYC((DIV < 2) ? 1 : DIV / 2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
);

// File: tb/frag_spi_master_tb.sv
`timescale 1ns/1ps
module frag_spi_master_tb;
    localparam int DW    = 32;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int LEN_W = $clog2(DW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_eop = 1'b0, cmd_wo = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic rd_ready = 1'b1;
    logic cmd_ready, rd_valid, sclk, mosi, miso, cs_n, busy;
    logic [DW-1:0] rd_data;

    always #2.5 clk = ~clk;

    frag_spi_master #(.DW(DW), .DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_len(cmd_len), .cmd_eop(cmd_eop), .cmd_wo(cmd_wo), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model: bit stream per frame, advancing on each falling SCLK
    logic [63:0] slave_word = 64'hC3A5_0F96_5A3C_E187;
    logic [5:0]  fidx = '0;
    always @(negedge cs_n) fidx = '0;
    always @(negedge sclk) if (!cs_n) fidx = fidx + 1'b1;
    assign miso = slave_word[6'd63 - fidx];

    // scoreboard queues
    bit           exp_mosi[$];
    logic [DW-1:0] exp_rd[$];
    int           rises = 0;
    int           exp_fidx = 0;

    // MOSI monitor (R1)
    always @(posedge sclk) begin
        rises++;
        if (exp_mosi.size() == 0) begin
            chk(1'b0, "R2 unexpected SCLK edge", 1, 0);
        end else begin
            bit e;
            e = exp_mosi.pop_front();
            chk(mosi == e, "R1 MOSI bit", mosi, e);
        end
    end

    // read stream monitor (R3, R4) and edge timing monitor (R2, R6, R8)
    bit prev_sclk = 1'b0, prev_cs = 1'b1;
    int lowcnt = 0, hicnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && rd_ready) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R4 unexpected read word", rd_data, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_data == e, "R3 read word", rd_data, e);
                end
            end
            if (sclk && !prev_sclk) chk(lowcnt >= HALF, "R8 setup before rise", lowcnt, HALF);
            if (!sclk && prev_sclk) chk(hicnt == HALF, "R2 high phase", hicnt, HALF);
            if (cs_n && !prev_cs)   chk(lowcnt >= HALF, "R6 hold before release", lowcnt, HALF);
            lowcnt = (!cs_n && !sclk) ? lowcnt + 1 : 0;
            hicnt  = sclk ? hicnt + 1 : 0;
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    task automatic send(input int len, input bit eop, input bit wo,
                        input logic [DW-1:0] wd, input bit wait_done);
        int r0;
        int n;
        logic [DW-1:0] v;
        n = (len > DW) ? DW : len;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        if (cs_n) exp_fidx = 0;
        for (int i = 0; i < n; i++) exp_mosi.push_back(wd[DW-1-i]);
        if (!wo && n > 0) begin
            v = '0;
            for (int i = 0; i < n; i++) v = {v[DW-2:0], slave_word[63 - ((exp_fidx + i) % 64)]};
            exp_rd.push_back(v);
        end
        exp_fidx += n;
        r0 = rises;
        cmd_valid = 1'b1; cmd_len = LEN_W'(len); cmd_eop = eop; cmd_wo = wo; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (n > 0) begin
            @(posedge sclk);
            @(negedge clk);
            chk(cmd_ready == 1'b0, "R9 ready low while shifting", cmd_ready, 0);
            chk(busy == 1'b1, "R10 busy while shifting", busy, 1);
        end
        if (wait_done) begin
            while (!cmd_ready) @(negedge clk);
            chk(rises - r0 == n, "R2 edges per fragment", rises - r0, n);
            if (eop) begin
                chk(cs_n == 1'b1, "R6 select released", cs_n, 1);
                chk(busy == 1'b0, "R10 idle after frame", busy, 0);
            end else begin
                chk(cs_n == 1'b0 && sclk == 1'b0, "R5 select held", {cs_n, sclk}, 0);
                chk(busy == 1'b1, "R10 busy while held", busy, 1);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R11 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R11 reset sclk", sclk, 0);
        chk(busy == 1'b0, "R11 reset busy", busy, 0);
        chk(rd_valid == 1'b0, "R11 reset rd_valid", rd_valid, 0);
        chk(cmd_ready == 1'b1, "R11 reset cmd_ready", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // opcode then chained 32-bit read (R1, R3, R5, R6)
        send(8, 1'b0, 1'b1, 32'hA500_0000, 1'b1);
        send(32, 1'b1, 1'b0, 32'h1234_5678, 1'b1);

        // single 16-bit read, new frame restarts the slave stream (R3)
        slave_word = 64'h0123_4567_89AB_CDEF;
        send(16, 1'b1, 1'b0, 32'hF0F0_0000, 1'b1);

        // write-only frame yields no read word (R4)
        send(12, 1'b1, 1'b1, 32'hABC0_0000, 1'b1);
        chk(exp_rd.size() == 0, "R4 no word after write-only", exp_rd.size(), 0);

        // zero-length release while idle has no effect (R7)
        send(0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1);
        chk(cs_n == 1'b1, "R7 idle release ignored", cs_n, 1);
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && rd_valid == 1'b0, "R7 still idle", {cs_n, rd_valid}, 2);

        // zero-length hold, read chained, then zero-length release (R7, R3)
        slave_word = 64'h8000_0001_FFFF_0000;
        send(0, 1'b0, 1'b0, '0, 1'b1);
        chk(cs_n == 1'b0, "R7 zero-length asserts select", cs_n, 0);
        send(1, 1'b0, 1'b0, 32'h8000_0000, 1'b1);
        send(7, 1'b0, 1'b0, 32'h5400_0000, 1'b1);
        send(0, 1'b1, 1'b1, '0, 1'b1);
        chk(cs_n == 1'b1, "R7 zero-length release", cs_n, 1);

        // 40-bit frame from two fragments, oversized length clamps (R2)
        send(8, 1'b0, 1'b0, 32'h3C00_0000, 1'b1);
        send(40, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1);

        // back-pressure on the read stream (R4, R9)
        rd_ready = 1'b0;
        send(16, 1'b1, 1'b0, 32'h5555_0000, 1'b0);
        while (!rd_valid) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(rd_valid == 1'b1, "R4 word held", rd_valid, 1);
        chk(cmd_ready == 1'b0, "R9 ready low while word pending", cmd_ready, 0);
        rd_ready = 1'b1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        chk(cs_n == 1'b1, "R6 released after pending read", cs_n, 1);

        repeat (10) @(negedge clk);
        chk(exp_rd.size() == 0, "R4 all words returned", exp_rd.size(), 0);
        chk(exp_mosi.size() == 0, "R1 all bits sent", exp_mosi.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule